// File: doc/BRIEF.md
# Two-Bit Branch Predictor with Target Buffer

This block predicts branches in the fetch stage. A direct-mapped table holds one entry for each index. Every entry has a valid bit, an address tag, a cached branch target and a two-bit saturating direction counter. The table is indexed by the fetch address with its two byte-offset bits dropped. For each fetch address the block returns, in the same cycle, a taken flag and the address to fetch next. That address is the cached target when the entry hits and its counter leans taken, and the sequential address otherwise.

When a branch resolves later in the pipeline, the resolving stage presents the branch address, the real direction and the real target on the update port. In that same cycle the block reports whether the prediction the table holds for that branch was wrong, so the pipeline can discard the wrong-path work. On the next clock edge it trains the counter and records the target. The mispredict report assumes the table entry has not changed between the fetch and the resolution of that branch. The two-bit hysteresis means a loop-closing branch costs one misprediction per loop exit instead of two.

Top module: `branch_predictor`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid and the counters hold 00, so every fetch returns taken=0 and next address = fetch address + 4.
- R2: A fetch that misses (entry invalid or tag bits [31:6] different) predicts not-taken and returns fetch address + 4.
- R3: An update marked taken for an address that misses allocates the entry. It becomes valid, takes the tag and target, and its counter starts at 10 (weak taken). A following fetch of that address predicts taken and returns the target.
- R4: An update marked not-taken for an address that misses changes nothing in the table.
- R5: The counter encodes 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. Its MSB is the predicted direction. A hitting update counts up on taken and down on not-taken, and stays put at 11 and at 00.
- R6: A strong-taken entry still predicts taken after one not-taken update. The direction flips only after a second consecutive not-taken update.
- R7: Two addresses that share index bits [5:2] but differ in tag bits [31:6] do not hit each other's entry. A taken update for one of them replaces the other's entry.
- R8: The mispredict output is high in the update cycle when the predicted direction (hit AND counter MSB) differs from the resolved direction.
- R9: When a taken prediction meets a taken outcome whose target differs from the cached one, mispredict is high, and the new target replaces the cached one.
- R10: Address bits [1:0] take no part in index or tag: fetch addresses that differ only there give the same prediction.
- R11: With the update valid input low, mispredict stays low and the table is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched |
| pred_taken | output | 1 | Fetch is predicted to be a taken branch |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | PC_W | Resolved target address |
| mispredict | output | 1 | The stored prediction for upd_pc was wrong |

## Verification
The hardest state to reach from the ports is a counter at either saturation end, and a hitting entry whose cached target is stale while its counter leans taken. Both take a chain of updates to one address in consecutive cycles. The stimulus walks a single entry through 10, 11, 11, 10, 01, 00, 00, 01 and 10, checking the fetch prediction before each step. It then resolves that branch to a new target. Aliasing is reached by driving a second address that shares the index but has a different tag.

// File: rtl/bp_pkg.sv
// Shared types for the branch predictor: the direction counter encoding.
package bp_pkg;
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_t;

    // Byte-offset bits that never take part in index or tag
    localparam int ALIGN_BITS = 2;
endpackage

// File: rtl/bp_ctr_step.sv
// Saturating two-bit counter step: one count toward the resolved direction.
// Assumes the caller applies the result only for a hitting entry.
module bp_ctr_step
    import bp_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);
    // Move one step, holding at both ends
    always_comb begin
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            default:       nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
        endcase
    end
endmodule

// File: rtl/bp_lookup.sv
// Hit and direction decision for one entry read from the table.
// Assumes the entry fields come from the index of the same address.
module bp_lookup
    import bp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TAG_W = 26
) (
    input  logic [TAG_W-1:0] addr_tag,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  ctr_t             ent_ctr,
    input  logic [PC_W-1:0]  ent_tgt,
    output logic             hit,
    output logic             lean_taken,
    output logic [PC_W-1:0]  tgt
);
    // Hit needs a valid entry with a matching tag; the counter MSB is the direction
    always_comb begin
        hit        = ent_valid && (ent_tag == addr_tag);
        lean_taken = hit && ent_ctr[1];
        tgt        = ent_tgt;
    end
endmodule

// File: rtl/bp_table.sv
// Direct-mapped predictor storage with two read ports and one write port.
// A write always leaves the entry valid. Reads see the state before the edge.
module bp_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    parameter int TAG_W   = 26,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd0_idx,
    output logic             rd0_valid,
    output logic [TAG_W-1:0] rd0_tag,
    output ctr_t             rd0_ctr,
    output logic [PC_W-1:0]  rd0_tgt,
    input  logic [IDX_W-1:0] rd1_idx,
    output logic             rd1_valid,
    output logic [TAG_W-1:0] rd1_tag,
    output ctr_t             rd1_ctr,
    output logic [PC_W-1:0]  rd1_tgt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  ctr_t             wr_ctr,
    input  logic             wr_tgt_en,
    input  logic [PC_W-1:0]  wr_tgt
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    ctr_t               ctr_q [ENTRIES];
    logic [PC_W-1:0]    tgt_q [ENTRIES];

    // Reset clears every entry to invalid and strong not-taken; otherwise write one entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                ctr_q[i] <= CTR_STRONG_NT;
                tgt_q[i] <= '0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
            ctr_q[wr_idx]   <= wr_ctr;
            if (wr_tgt_en) tgt_q[wr_idx] <= wr_tgt;
        end
    end

    // Combinational read ports
    always_comb begin
        rd0_valid = valid_q[rd0_idx];
        rd0_tag   = tag_q[rd0_idx];
        rd0_ctr   = ctr_q[rd0_idx];
        rd0_tgt   = tgt_q[rd0_idx];
        rd1_valid = valid_q[rd1_idx];
        rd1_tag   = tag_q[rd1_idx];
        rd1_ctr   = ctr_q[rd1_idx];
        rd1_tgt   = tgt_q[rd1_idx];
    end

    // Per-entry checks
    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        // R3: a write leaves the entry valid
        a_r3_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> valid_q[g]);
        // R11: with no write the entry does not move
        a_r11_entry_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> ($stable(valid_q[g]) && $stable(ctr_q[g]) && $stable(tgt_q[g])));
    end
endmodule

// File: rtl/branch_predictor.sv
// Fetch-stage two-bit direction predictor with a tagged target cache.
// Fetch lookup is combinational. The update port reports a mispredict in the same
// cycle and trains the table on the next edge. Word-aligned addresses are assumed.
module branch_predictor
    import bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    output logic            mispredict
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - ALIGN_BITS;
    localparam int IDX_LO = ALIGN_BITS;
    localparam int TAG_LO = ALIGN_BITS + IDX_W;

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             f_valid, u_valid;
    logic [TAG_W-1:0] f_etag, u_etag;
    ctr_t             f_ctr, u_ctr, u_ctr_step, wr_ctr;
    logic [PC_W-1:0]  f_etgt, u_etgt, f_tgt, u_tgt;
    logic             f_hit, f_lean, u_hit, u_lean;
    logic             wr_en;

    // Split both addresses into index and tag
    always_comb begin
        f_idx = fetch_pc[TAG_LO-1:IDX_LO];
        f_tag = fetch_pc[PC_W-1:TAG_LO];
        u_idx = upd_pc[TAG_LO-1:IDX_LO];
        u_tag = upd_pc[PC_W-1:TAG_LO];
    end

    bp_table #(.ENTRIES(ENTRIES), .PC_W(PC_W), .TAG_W(TAG_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(f_idx), .rd0_valid(f_valid), .rd0_tag(f_etag), .rd0_ctr(f_ctr), .rd0_tgt(f_etgt),
        .rd1_idx(u_idx), .rd1_valid(u_valid), .rd1_tag(u_etag), .rd1_ctr(u_ctr), .rd1_tgt(u_etgt),
        .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(u_tag), .wr_ctr(wr_ctr),
        .wr_tgt_en(upd_taken), .wr_tgt(upd_target)
    );

    bp_lookup #(.PC_W(PC_W), .TAG_W(TAG_W)) u_fetch_look (
        .addr_tag(f_tag), .ent_valid(f_valid), .ent_tag(f_etag), .ent_ctr(f_ctr),
        .ent_tgt(f_etgt), .hit(f_hit), .lean_taken(f_lean), .tgt(f_tgt)
    );

    bp_lookup #(.PC_W(PC_W), .TAG_W(TAG_W)) u_upd_look (
        .addr_tag(u_tag), .ent_valid(u_valid), .ent_tag(u_etag), .ent_ctr(u_ctr),
        .ent_tgt(u_etgt), .hit(u_hit), .lean_taken(u_lean), .tgt(u_tgt)
    );

    bp_ctr_step u_step (.cur(u_ctr), .taken(upd_taken), .nxt(u_ctr_step));

    // Fetch result: cached target on a taken lean, else the sequential address
    always_comb begin
        pred_taken   = f_lean;
        pred_next_pc = f_lean ? f_tgt : (fetch_pc + PC_W'(4));
    end

    // Training: step a hitting entry, allocate at weak taken on a taken miss
    always_comb begin
        wr_en  = upd_valid && (u_hit || upd_taken);
        wr_ctr = u_hit ? u_ctr_step : CTR_WEAK_T;
    end

    // Wrong direction, or taken both ways but to another target
    always_comb begin
        mispredict = upd_valid &&
                     ((u_lean != upd_taken) || (u_lean && upd_taken && (u_tgt != upd_target)));
    end

    // R2: a miss never redirects fetch
    a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        !f_hit |-> (!pred_taken && pred_next_pc == fetch_pc + PC_W'(4)));
    // R8: a direction disagreement on a hit is always reported
    a_r8_dir_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && u_hit && (u_ctr[1] != upd_taken)) |-> mispredict);
    // R11: no report without a valid update
    a_r11_no_report_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> !mispredict);
    // R6: one not-taken only weakens a strong-taken entry
    a_r6_hysteresis: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && u_hit && u_ctr == CTR_STRONG_T && !upd_taken) |-> (wr_ctr == CTR_WEAK_T));
    // R5: saturation at the top
    a_r5_saturate_top: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && u_hit && u_ctr == CTR_STRONG_T && upd_taken) |-> (wr_ctr == CTR_STRONG_T));
endmodule

// File: tb/tb_branch_predictor.sv
// Scoreboard bench: the driver queues expected results, the monitor compares at negedge.
module tb_branch_predictor;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_taken;
    logic [PC_W-1:0] pred_next_pc;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [PC_W-1:0] upd_target = '0;
    logic            mispredict;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        string           req;
        logic            pt;
        logic [PC_W-1:0] np;
        logic            mp;
    } exp_t;
    exp_t exp_q[$];

    branch_predictor #(.PC_W(PC_W), .ENTRIES(16)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
        .pred_next_pc(pred_next_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target), .mispredict(mispredict)
    );

    always #2 clk = ~clk;

    // Driver: one fetch plus an optional update per cycle, expected result queued
    task automatic op(input logic [PC_W-1:0] fpc, input logic ept, input logic [PC_W-1:0] enp,
                      input logic uv, input logic [PC_W-1:0] upc, input logic ut,
                      input logic [PC_W-1:0] utg, input logic emp, input string req);
        exp_t e;
        @(posedge clk);
        #1;
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
        e.req = req; e.pt = ept; e.np = enp; e.mp = emp;
        exp_q.push_back(e);
    endtask

    // Monitor: compare the queued expectation against the outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks += 3;
            if (pred_taken !== e.pt) begin
                failures++;
                $display("FAIL %s pred_taken actual=%0b expected=%0b", e.req, pred_taken, e.pt);
            end
            if (pred_next_pc !== e.np) begin
                failures++;
                $display("FAIL %s next_pc actual=%h expected=%h", e.req, pred_next_pc, e.np);
            end
            if (mispredict !== e.mp) begin
                failures++;
                $display("FAIL %s mispredict actual=%0b expected=%0b", e.req, mispredict, e.mp);
            end
        end
    end

    localparam logic [PC_W-1:0] A = 32'h0000_0100;
    localparam logic [PC_W-1:0] B = 32'h0000_0140; // same index as A, other tag
    localparam logic [PC_W-1:0] C = 32'h0000_0208;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        op(A, 0, A + 4, 0, 0, 0, 0, 0, "R1 reset");
        op(C, 0, C + 4, 1, C, 0, 32'h500, 0, "R4 nt miss update");
        op(C, 0, C + 4, 1, A, 1, 32'h800, 1, "R4/R8 no alloc, miss taken");
        op(A, 1, 32'h800, 1, A, 1, 32'h800, 0, "R3 alloc weak taken");
        op(A | 32'h2, 1, 32'h800, 1, A, 1, 32'h800, 0, "R10 low bits ignored");
        op(A, 1, 32'h800, 1, A, 0, 32'h0, 1, "R5 strong taken, R8 nt");
        op(A, 1, 32'h800, 1, A, 0, 32'h0, 1, "R6 hysteresis");
        op(A, 0, A + 4, 1, A, 0, 32'h0, 0, "R5 flipped to weak nt");
        op(A, 0, A + 4, 1, A, 0, 32'h0, 0, "R5 saturate low");
        op(A, 0, A + 4, 1, A, 1, 32'h900, 1, "R5 strong nt");
        op(A, 0, A + 4, 1, A, 1, 32'h900, 1, "R5 weak nt");
        op(A, 1, 32'h900, 1, A, 1, 32'hA00, 1, "R9 target mismatch");
        op(B, 0, B + 4, 0, A, 0, 32'h0, 0, "R7 alias miss, R11 idle update");
        op(A, 1, 32'hA00, 1, B, 1, 32'hC00, 1, "R9 new target, R11 no effect");
        op(A, 0, A + 4, 0, 0, 0, 0, 0, "R7 evicted");
        op(B, 1, 32'hC00, 0, 0, 0, 0, 0, "R3 replacing entry");
        @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #20000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule